// File: doc/BRIEF.md
# Branch Trace Logger

This block sits beside the retirement stage of a processor core. It watches an event port that reports taken branches, interrupts and exceptions, and turns each event into a 64-bit trace record made of the source address and the target address. A three-bit debug-control register decides what happens to each record. The record can be sent out as a trace message on a valid/ready port, written into a small on-chip trace buffer, or both.

The buffer is written through an internal write index that the block exposes. A buffer-state machine has three states. FILLING is the state before the buffer first fills. WRAPPING means the buffer has been filled at least once and logging continues circularly. HALTED means the buffer is full in stop mode. In HALTED the interrupt output is asserted and new events are not stored. A clear strobe returns the buffer to FILLING. Software reads the buffer by index on a combinational read port.

The message path is a second state machine. Its states are IDLE (no message), SEND (one message presented) and SKID (one message presented and one more held in the skid register). A third event that arrives while both slots are occupied is dropped and sets a sticky overflow flag.

Top module: `branch_trace_logger`

## Requirements
- R1: The control register holds three fields: bit 6 is message enable, bit 7 is store enable and bit 8 is stop-on-full. Each field reads back the last value written to it, and every other bit reads as zero. The register resets to zero. A write takes effect for events in the cycle after the write.
- R2: `evt_kind` is encoded as 0 for a taken branch, 1 for an interrupt and 2 for an exception. All three are logged. Code 3 is not a valid event: it produces no message, no buffer write and no index change.
- R3: A record carries the from-address in bits 31:0 and the to-address in bits 63:32, both in the buffer and on `msg_data`. `msg_kind` carries the event code.
- R4: With message enable set, each valid event produces exactly one message, in event order, and `msg_valid` rises in the cycle after the event. With message enable clear, no message is produced.
- R5: With store enable set, a valid event writes its record at `wr_idx`, and `wr_idx` advances by one in the next cycle. With store enable clear, or with no event, `wr_idx` holds.
- R6: In wrap mode (bit 8 clear), writing the last entry (DEPTH-1) moves the buffer to WRAPPING and returns `wr_idx` to 0. Later events overwrite the oldest entries. `buf_full` is high from then on until a clear.
- R7: In stop mode (bit 8 set), writing the last entry moves the buffer to HALTED. `trace_irq` stays high there, further events are not stored, and `wr_idx` holds.
- R8: `idx_clr` zeroes `wr_idx` and drops `buf_full`, `trace_irq` and `skid_ovf` in the next cycle. A buffer write requested in the same cycle is discarded.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_data` and `msg_kind` stay stable. One further event is held in the skid register and delivered after the presented message.
- R10: An event that arrives while a message is stalled and the skid register is occupied is dropped, and `skid_ovf` is set. It stays set until `idx_clr`.
- R11: Setting bit 8 while in WRAPPING moves the buffer to HALTED on the next edge, with no store in that cycle. Clearing bit 8 while in HALTED moves it to WRAPPING on the next edge, with no store in that cycle. Logging then resumes at `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Retirement event present this cycle |
| evt_kind | input | 2 | Event code (0 branch, 1 interrupt, 2 exception) |
| evt_from | input | 32 | Source address of the event |
| evt_to | input | 32 | Target address of the event |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rdata | output | 32 | Control register read value |
| idx_clr | input | 1 | Clear strobe: zeroes write index, full, interrupt, overflow |
| wr_idx | output | $clog2(DEPTH) | Next buffer entry to be written |
| buf_full | output | 1 | Buffer has been filled at least once since clear |
| trace_irq | output | 1 | Level interrupt: buffer full in stop mode |
| rd_idx | input | $clog2(DEPTH) | Buffer read index |
| rd_data | output | 64 | Buffer entry at `rd_idx` |
| msg_valid | output | 1 | Trace message presented |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_kind | output | 2 | Event code of the presented message |
| msg_data | output | 64 | Record of the presented message |
| skid_ovf | output | 1 | Sticky: a message was lost to back-pressure |

## Verification
The bench targets the last-entry boundary in both modes. A wrong wrap comparison would either stop one entry early or index past the buffer, and a wrong mode decode would halt in wrap mode or overwrite the oldest entries in stop mode. It stalls the message port with one, two and three events outstanding. A broken skid path would either drop the second event or replace the stalled message, and an overflow detector that fires one slot too early or too late would mark a delivered message as lost. It also drives the clear strobe and an event in the same cycle, and switches bit 8 back and forth while the buffer is full. These expose a clear that lets the store through, and a mode change that stores a record it should drop.

// File: rtl/btl_pkg.sv
package btl_pkg;

    localparam int ADDR_W  = 32;
    localparam int REC_W   = 2 * ADDR_W;
    localparam int KIND_W  = 2;
    localparam int CTL_W   = 32;

    localparam int BIT_MSG_EN   = 6;
    localparam int BIT_STORE_EN = 7;
    localparam int BIT_STOP     = 8;

    localparam logic [CTL_W-1:0] CTL_MASK =
        (CTL_W'(1) << BIT_MSG_EN) | (CTL_W'(1) << BIT_STORE_EN) | (CTL_W'(1) << BIT_STOP);

    typedef enum logic [KIND_W-1:0] {
        EV_BRANCH = 2'd0,
        EV_INTR   = 2'd1,
        EV_EXCP   = 2'd2,
        EV_NONE   = 2'd3
    } ev_kind_t;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] to_addr;
        logic [ADDR_W-1:0] from_addr;
    } trace_rec_t;

    typedef struct packed {
        logic stop_on_full;
        logic store_en;
        logic msg_en;
    } ctl_bits_t;

    typedef enum logic [1:0] {
        SF_FILLING,
        SF_WRAPPING,
        SF_HALTED
    } store_state_t;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_SEND,
        MS_SKID
    } msg_state_t;

endpackage

// File: rtl/btl_ctrl_reg.sv
module btl_ctrl_reg
    import btl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output ctl_bits_t        bits
);

    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= wr_data & CTL_MASK;
        end
    end

    always_comb begin
        rd_data           = ctl_q;
        bits.msg_en       = ctl_q[BIT_MSG_EN];
        bits.store_en     = ctl_q[BIT_STORE_EN];
        bits.stop_on_full = ctl_q[BIT_STOP];
    end

endmodule

// File: rtl/btl_store.sv
module btl_store
    import btl_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [REC_W-1:0] wr_rec,
    input  logic             stop_mode,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REC_W-1:0] rd_data,
    output logic [IDX_W-1:0] wr_idx,
    output logic             full,
    output logic             irq
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    store_state_t     state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             mem_we;
    logic             at_last;
    logic [REC_W-1:0] ent_q [DEPTH];

    assign at_last = (ptr_q == LAST_IDX);

    // Next-state and write-enable decode
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        mem_we  = 1'b0;
        if (clr) begin
            state_d = SF_FILLING;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                SF_FILLING: begin
                    if (wr_req) begin
                        mem_we = 1'b1;
                        if (at_last) begin
                            ptr_d   = '0;
                            state_d = stop_mode ? SF_HALTED : SF_WRAPPING;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                SF_WRAPPING: begin
                    if (stop_mode) begin
                        state_d = SF_HALTED;
                    end else if (wr_req) begin
                        mem_we = 1'b1;
                        ptr_d  = at_last ? '0 : ptr_q + 1'b1;
                    end
                end
                SF_HALTED: begin
                    if (!stop_mode) begin
                        state_d = SF_WRAPPING;
                    end
                end
                default: begin
                    state_d = SF_FILLING;
                    ptr_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SF_FILLING;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Buffer storage
    always_ff @(posedge clk) begin
        if (mem_we) begin
            ent_q[ptr_q] <= wr_rec;
        end
    end

    // Outputs
    always_comb begin
        rd_data = ent_q[rd_idx];
        wr_idx  = ptr_q;
        full    = (state_q != SF_FILLING);
        irq     = (state_q == SF_HALTED);
    end

endmodule

// File: rtl/btl_msg_port.sv
module btl_msg_port
    import btl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  trace_rec_t push_rec,
    input  logic       clr,
    input  logic       ready,
    output logic       valid,
    output trace_rec_t out_rec,
    output logic       ovf
);

    msg_state_t state_q, state_d;
    trace_rec_t out_q, skid_q;
    logic       ovf_q;
    logic       lose;

    assign lose = (state_q == MS_SKID) && !ready && push;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: begin
                if (push) state_d = MS_SEND;
            end
            MS_SEND: begin
                if (ready && !push)      state_d = MS_IDLE;
                else if (!ready && push) state_d = MS_SKID;
            end
            MS_SKID: begin
                if (ready && !push) state_d = MS_SEND;
            end
            default: state_d = MS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Message and skid registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            skid_q <= '0;
        end else begin
            unique case (state_q)
                MS_IDLE: begin
                    if (push) out_q <= push_rec;
                end
                MS_SEND: begin
                    if (push) begin
                        if (ready) out_q  <= push_rec;
                        else       skid_q <= push_rec;
                    end
                end
                MS_SKID: begin
                    if (ready) begin
                        out_q <= skid_q;
                        if (push) skid_q <= push_rec;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (clr)  ovf_q <= 1'b0;
        else if (lose) ovf_q <= 1'b1;
    end

    // Outputs
    always_comb begin
        valid   = (state_q != MS_IDLE);
        out_rec = out_q;
        ovf     = ovf_q;
    end

endmodule

// File: rtl/branch_trace_logger.sv
module branch_trace_logger
    import btl_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [KIND_W-1:0] evt_kind,
    input  logic [ADDR_W-1:0] evt_from,
    input  logic [ADDR_W-1:0] evt_to,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              idx_clr,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              buf_full,
    output logic              trace_irq,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [REC_W-1:0]  rd_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [KIND_W-1:0] msg_kind,
    output logic [REC_W-1:0]  msg_data,
    output logic              skid_ovf
);

    ctl_bits_t  ctl;
    trace_rec_t rec;
    trace_rec_t msg_rec;
    logic       evt_ok;

    assign evt_ok = evt_valid && (evt_kind != EV_NONE);

    always_comb begin
        rec.kind      = evt_kind;
        rec.to_addr   = evt_to;
        rec.from_addr = evt_from;
    end

    btl_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .rd_data (ctl_rdata),
        .bits    (ctl)
    );

    btl_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (evt_ok && ctl.store_en),
        .wr_rec    ({rec.to_addr, rec.from_addr}),
        .stop_mode (ctl.stop_on_full),
        .clr       (idx_clr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .wr_idx    (wr_idx),
        .full      (buf_full),
        .irq       (trace_irq)
    );

    btl_msg_port u_msg (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (evt_ok && ctl.msg_en),
        .push_rec (rec),
        .clr      (idx_clr),
        .ready    (msg_ready),
        .valid    (msg_valid),
        .out_rec  (msg_rec),
        .ovf      (skid_ovf)
    );

    assign msg_kind = msg_rec.kind;
    assign msg_data = {msg_rec.to_addr, msg_rec.from_addr};

endmodule

// File: rtl/btl_checker.sv
module btl_checker
    import btl_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [KIND_W-1:0] evt_kind,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              idx_clr,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              buf_full,
    input logic              trace_irq,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [KIND_W-1:0] msg_kind,
    input logic [REC_W-1:0]  msg_data,
    input logic              skid_ovf
);

    assert_ctl_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata & ~CTL_MASK) == '0);

    assert_ctl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_rdata[BIT_STOP:BIT_MSG_EN] == $past(ctl_wdata[BIT_STOP:BIT_MSG_EN])));

    assert_bad_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd3 && !idx_clr) |=> $stable(wr_idx));

    assert_idle_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !idx_clr) |=> $stable(wr_idx));

    assert_irq_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trace_irq |-> buf_full);

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_irq && !idx_clr) |=> $stable(wr_idx));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr |=> (wr_idx == '0 && !buf_full && !trace_irq && !skid_ovf));

    assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_kind)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (skid_ovf && !idx_clr) |=> skid_ovf);

endmodule

bind branch_trace_logger btl_checker #(.DEPTH(DEPTH)) u_btl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .idx_clr   (idx_clr),
    .wr_idx    (wr_idx),
    .buf_full  (buf_full),
    .trace_irq (trace_irq),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_kind  (msg_kind),
    .msg_data  (msg_data),
    .skid_ovf  (skid_ovf)
);

// File: tb/branch_trace_logger_test.sv
module branch_trace_logger_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int IDX_W      = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic [31:0] evt_from = '0;
    logic [31:0] evt_to = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        idx_clr = 1'b0;
    logic [IDX_W-1:0] wr_idx;
    logic        buf_full;
    logic        trace_irq;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [63:0] rd_data;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [1:0]  msg_kind;
    logic [63:0] msg_data;
    logic        skid_ovf;

    branch_trace_logger #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_from(evt_from), .evt_to(evt_to), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .idx_clr(idx_clr), .wr_idx(wr_idx), .buf_full(buf_full),
        .trace_irq(trace_irq), .rd_idx(rd_idx), .rd_data(rd_data), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_data(msg_data), .skid_ovf(skid_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [1:0]  k;
        logic [63:0] d;
    } mmsg_t;

    // Behavioural reference state
    logic [31:0] m_ctl = '0;
    mmsg_t       m_q[$];
    int          m_ptr = 0;
    int          m_st = 0;      // 0 filling, 1 wrapping, 2 halted
    bit          m_ovf = 0;
    logic [63:0] m_mem [DEPTH];
    bit          m_vld [DEPTH];

    int    checks = 0;
    int    fails = 0;
    int    seq = 0;
    string cur = "R1";
    bit    done = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] %s actual=%h expected=%h", req, cur, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit          ok;
        logic [63:0] r;
        mmsg_t       m;
        ok = evt_valid && (evt_kind != 2'd3);
        r  = {evt_to, evt_from};
        if (m_q.size() > 0 && msg_ready) void'(m_q.pop_front());
        if (ok && m_ctl[6]) begin
            if (m_q.size() < 2) begin
                m.k = evt_kind;
                m.d = r;
                m_q.push_back(m);
            end else begin
                m_ovf = 1;
            end
        end
        if (idx_clr) begin
            m_ptr = 0;
            m_st  = 0;
            m_ovf = 0;
        end else begin
            case (m_st)
                0: if (ok && m_ctl[7]) begin
                    m_mem[m_ptr] = r;
                    m_vld[m_ptr] = 1;
                    if (m_ptr == DEPTH-1) begin
                        m_ptr = 0;
                        m_st  = m_ctl[8] ? 2 : 1;
                    end else begin
                        m_ptr++;
                    end
                end
                1: if (m_ctl[8]) begin
                    m_st = 2;
                end else if (ok && m_ctl[7]) begin
                    m_mem[m_ptr] = r;
                    m_vld[m_ptr] = 1;
                    m_ptr = (m_ptr + 1) % DEPTH;
                end
                default: if (!m_ctl[8]) m_st = 1;
            endcase
        end
        if (ctl_we) m_ctl = ctl_wdata & 32'h0000_01C0;
    endtask

    task automatic compare();
        chk("R1", "ctl_rdata", 64'(ctl_rdata), 64'(m_ctl));
        chk("R4/R9", "msg_valid", 64'(msg_valid), 64'(m_q.size() > 0));
        if (m_q.size() > 0) begin
            chk("R3/R9", "msg_data", msg_data, m_q[0].d);
            chk("R3", "msg_kind", 64'(msg_kind), 64'(m_q[0].k));
        end
        chk("R5", "wr_idx", 64'(wr_idx), 64'(m_ptr));
        chk("R6", "buf_full", 64'(buf_full), 64'(m_st != 0));
        chk("R7", "trace_irq", 64'(trace_irq), 64'(m_st == 2));
        chk("R10", "skid_ovf", 64'(skid_ovf), 64'(m_ovf));
        if (m_vld[rd_idx]) chk("R3/R6", "rd_data", rd_data, m_mem[rd_idx]);
    endtask

    task automatic cycle();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        compare();
        rd_idx = rd_idx + 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic ev(logic [1:0] k);
        evt_valid = 1'b1;
        evt_kind  = k;
        evt_from  = 32'h1000_0000 + 32'(seq);
        evt_to    = 32'hA000_0000 ^ (32'(seq) * 32'h0101_0103);
        seq++;
        cycle();
        evt_valid = 1'b0;
    endtask

    task automatic wctl(logic [31:0] d);
        ctl_we    = 1'b1;
        ctl_wdata = d;
        cycle();
        ctl_we    = 1'b0;
    endtask

    task automatic clear();
        idx_clr = 1'b1;
        cycle();
        idx_clr = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired in phase %s", cur);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
        @(negedge clk);
        cur = "R1";
        compare();
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reserved bits, field readback
        wctl(32'hFFFF_FFFF);
        wctl(32'h0000_0000);
        wctl(32'h0000_00C0);

        // R2 / R3: each kind and the invalid code
        cur = "R2";
        ev(2'd0); ev(2'd1); ev(2'd2); ev(2'd3); ev(2'd3);
        idle(2);

        // R4 / R5: enables separately
        cur = "R4";
        wctl(32'h0000_0080);
        ev(2'd0); ev(2'd1);
        idle(1);
        cur = "R5";
        wctl(32'h0000_0040);
        ev(2'd2); ev(2'd0);
        idle(2);
        wctl(32'h0000_00C0);

        // R9: stall with one and two outstanding
        cur = "R9";
        msg_ready = 1'b0;
        ev(2'd0);
        idle(1);
        ev(2'd1);
        idle(2);
        msg_ready = 1'b1;
        idle(3);
        msg_ready = 1'b0;
        ev(2'd2);
        msg_ready = 1'b1;
        ev(2'd1);
        idle(2);

        // R10: third event while stalled
        cur = "R10";
        msg_ready = 1'b0;
        ev(2'd0); ev(2'd1); ev(2'd2); ev(2'd0);
        idle(2);
        msg_ready = 1'b1;
        idle(4);

        // R8: clear drops overflow and index
        cur = "R8";
        clear();
        idle(1);

        // R6: wrap mode across the last entry
        cur = "R6";
        for (int i = 0; i < DEPTH + 5; i++) ev(2'(i % 3));
        idle(DEPTH);

        // R8: clear together with an event
        cur = "R8";
        idx_clr = 1'b1;
        ev(2'd1);
        idx_clr = 1'b0;
        idle(1);

        // R7: stop mode
        cur = "R7";
        wctl(32'h0000_01C0);
        for (int i = 0; i < DEPTH + 4; i++) ev(2'(i % 3));
        idle(DEPTH);

        // R11: leave and re-enter the halt through bit 8
        cur = "R11";
        wctl(32'h0000_00C0);
        ev(2'd0);
        ev(2'd2);
        ev(2'd1);
        ctl_we = 1'b1;
        ctl_wdata = 32'h0000_01C0;
        ev(2'd0);
        ctl_we = 1'b0;
        ev(2'd1);
        idle(3);
        wctl(32'h0000_00C0);
        msg_ready = 1'b0;
        ev(2'd2); ev(2'd0);
        msg_ready = 1'b1;
        idle(DEPTH);

        cur = "R8";
        clear();
        idle(2);

        done = 1;
        summary();
        $finish;
    end

endmodule